// File: doc/BRIEF.md
# Saturating Fault Tally with Latch-Off

This block keeps a running score of how switching cycles end and shuts the converter down for good when faults dominate. A PWM core marks the start of every switching cycle and then reports, by single-clock strobes, why the drive pulse ended: a normal peak-current trip, a maximum on-time timeout or an overcurrent trip. Fault endings raise a shared up/down counter and normal endings lower it, so isolated surges cancel out against healthy cycles. When the counter reaches a set limit, the block asserts latch-off, which the drive stage uses to hold the switch off.

A cycle that starts and never reports an ending, for example because PWM dimming cut the pulse, changes nothing. A run of fault-ended pulses inside short dimming windows can therefore add up to latch-off with no normal endings to cancel them. Only a supply power cycle, presented to the block as its reset, clears the latch.

The control is a four-state machine. IDLE: after reset, no cycle open. ARMED: a cycle is open and its first ending will be counted. SPENT: this cycle has already been counted and further strobes are ignored. LATCHED: the limit was reached. Transitions: IDLE or SPENT to ARMED on a cycle start. ARMED to LATCHED on a fault ending while the count is one below the limit. ARMED stays ARMED on a cycle start, counting any ending that arrives in the same clock. ARMED to SPENT on any other ending. ARMED stays ARMED with no strobe. LATCHED is left only through reset.

Top module: `fault_tally_latch`

## Requirements
- R1: While and after reset (rst_n low), fault_count is 0 and latch_off is 0.
- R2: An end_maxon strobe in an open cycle raises fault_count by 1, visible after the next rising clock edge.
- R3: An end_ocp strobe in an open cycle raises fault_count by 1.
- R4: An end_normal strobe in an open cycle lowers fault_count by 1.
- R5: An end_normal strobe with fault_count at 0 leaves it at 0; the counter never wraps below zero.
- R6: At most one count is taken per switching cycle. Strobes after the first counted one, and strobes before any cycle_start since reset or since the last counted ending, are ignored.
- R7: When several strobes arrive in one clock of an open cycle, end_ocp wins over end_maxon, and end_maxon wins over end_normal; only the winner is counted.
- R8: A cycle that gets no ending strobe, such as a pulse cut short by dimming, changes nothing. A new cycle_start keeps the cycle open, and a strobe in the same clock as cycle_start counts toward the cycle already open.
- R9: A fault ending that brings fault_count to LIMIT (default 8) sets latch_off after the same clock edge that updates the count, and fault_count then reads LIMIT.
- R10: Once latch_off is set, it and fault_count stay unchanged under any strobe or cycle_start until rst_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; asserted for a supply power cycle |
| cycle_start | input | 1 | One-clock strobe at the start of a switching cycle |
| end_normal | input | 1 | Pulse ended on the peak-current comparator |
| end_maxon | input | 1 | Pulse ended on the maximum on-time limit |
| end_ocp | input | 1 | Pulse ended on the overcurrent comparator |
| fault_count | output | $clog2(LIMIT+1) | Present counter value |
| latch_off | output | 1 | Drive permanently disabled |

## Verification
The hardest case is the accumulation with no cancelling endings: a count one below the limit is reachable only after several fault cycles, and on the way there the bench must show that ignored strobes really are ignored. These are late strobes in a spent cycle, strobes before any start, and empty cycles that mimic dimming cut-offs. The stimulus walks the counter up and down through mixed and simultaneous strobes, adds empty cycles, and only then drives the final fault cycle to the limit. After that it sends every strobe type to show that the latch holds until reset.

// File: rtl/fault_tally_pkg.sv
package fault_tally_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_NORM  = 2'd1,
        EV_MAXON = 2'd2,
        EV_OCP   = 2'd3
    } term_ev_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SPENT   = 2'd2,
        ST_LATCHED = 2'd3
    } tally_st_e;

    function automatic logic is_fault(input term_ev_e ev);
        return (ev == EV_MAXON) || (ev == EV_OCP);
    endfunction

endpackage

// File: rtl/fc_term_arbiter.sv
module fc_term_arbiter
    import fault_tally_pkg::*;
(
    input  logic     end_normal,
    input  logic     end_maxon,
    input  logic     end_ocp,
    output term_ev_e ev
);

    // Overcurrent outranks max on-time, which outranks a normal trip (R7)
    always_comb begin
        if (end_ocp)
            ev = EV_OCP;
        else if (end_maxon)
            ev = EV_MAXON;
        else if (end_normal)
            ev = EV_NORM;
        else
            ev = EV_NONE;
    end

endmodule

// File: rtl/fc_sat_counter.sv
module fc_sat_counter #(
    parameter int LIMIT = 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          at_pre,
    output logic          at_zero
);

    localparam logic [CW-1:0] TOP = CW'(LIMIT);
    localparam logic [CW-1:0] PRE = CW'(LIMIT - 1);

    assign at_pre  = (count == PRE);
    assign at_zero = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
        else if (dec && !at_zero)
            count <= count - 1'b1;
    end

endmodule

// File: rtl/fc_ctrl_fsm.sv
module fc_ctrl_fsm
    import fault_tally_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cycle_start,
    input  term_ev_e ev,
    input  logic     at_pre,
    output logic     inc,
    output logic     dec,
    output logic     latched
);

    tally_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_SPENT: begin
                if (cycle_start)
                    state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (is_fault(ev) && at_pre)
                    state_nx = ST_LATCHED;
                else if (cycle_start)
                    state_nx = ST_ARMED;
                else if (ev != EV_NONE)
                    state_nx = ST_SPENT;
            end
            ST_LATCHED: state_nx = ST_LATCHED;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        inc     = 1'b0;
        dec     = 1'b0;
        latched = 1'b0;
        unique case (state)
            ST_ARMED: begin
                inc = is_fault(ev);
                dec = (ev == EV_NORM);
            end
            ST_LATCHED: latched = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fault_tally_latch.sv
module fault_tally_latch
    import fault_tally_pkg::*;
#(
    parameter int LIMIT = 8,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cycle_start,
    input  logic          end_normal,
    input  logic          end_maxon,
    input  logic          end_ocp,
    output logic [CW-1:0] fault_count,
    output logic          latch_off
);

    term_ev_e ev;
    logic     inc, dec, at_pre, at_zero;

    fc_term_arbiter arb_i (
        .end_normal (end_normal),
        .end_maxon  (end_maxon),
        .end_ocp    (end_ocp),
        .ev         (ev)
    );

    fc_ctrl_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .ev          (ev),
        .at_pre      (at_pre),
        .inc         (inc),
        .dec         (dec),
        .latched     (latch_off)
    );

    fc_sat_counter #(.LIMIT(LIMIT), .CW(CW)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .dec     (dec),
        .count   (fault_count),
        .at_pre  (at_pre),
        .at_zero (at_zero)
    );

endmodule

// File: rtl/fault_tally_chk.sv
module fault_tally_chk #(
    parameter int LIMIT = 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cycle_start,
    input logic          end_normal,
    input logic          end_maxon,
    input logic          end_ocp,
    input logic [CW-1:0] fault_count,
    input logic          latch_off
);

    // R9
    latch_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_off == (fault_count == CW'(LIMIT)));

    // R10
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_off |=> latch_off);

    // R10
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_off |=> $stable(fault_count));

    // R5
    zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count == '0 && end_normal && !end_maxon && !end_ocp) |=> fault_count == '0);

    // R6
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_count) |->
            ({1'b0, fault_count} == {1'b0, $past(fault_count)} + 1'b1) ||
            ({1'b0, fault_count} + 1'b1 == {1'b0, $past(fault_count)}));

    // R2
    rise_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count > $past(fault_count)) |-> $past(end_maxon || end_ocp));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (fault_count == '0 && !latch_off));

endmodule

bind fault_tally_latch fault_tally_chk #(.LIMIT(LIMIT), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .end_normal  (end_normal),
    .end_maxon   (end_maxon),
    .end_ocp     (end_ocp),
    .fault_count (fault_count),
    .latch_off   (latch_off)
);

// File: tb/fault_tally_latch_tb_top.sv
module fault_tally_latch_tb_top;

    localparam int LIMIT = 8;
    localparam int CW    = $clog2(LIMIT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_start = 1'b0;
    logic          end_normal = 1'b0;
    logic          end_maxon = 1'b0;
    logic          end_ocp = 1'b0;
    logic [CW-1:0] fault_count;
    logic          latch_off;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    cnt;
        bit    lat;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state
    int m_cnt    = 0;
    bit m_armed  = 1'b0;
    bit m_latch  = 1'b0;

    always #5 clk = ~clk;

    fault_tally_latch #(.LIMIT(LIMIT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .end_normal  (end_normal),
        .end_maxon   (end_maxon),
        .end_ocp     (end_ocp),
        .fault_count (fault_count),
        .latch_off   (latch_off)
    );

    task automatic compare(input int cnt, input bit lat, input string tag);
        checks++;
        if (int'(fault_count) != cnt || latch_off != lat) begin
            errors++;
            $display("FAIL %s: count=%0d latch=%0b expected count=%0d latch=%0b",
                     tag, fault_count, latch_off, cnt, lat);
        end
    endtask

    // one clock of stimulus; model computes the expected outputs after the edge
    task automatic step(input bit s, input bit n, input bit m, input bit o,
                        input string tag);
        exp_t e;
        @(negedge clk);
        cycle_start = s;
        end_normal  = n;
        end_maxon   = m;
        end_ocp     = o;
        if (!m_latch) begin
            bit counted = 1'b0;
            if (m_armed && (o || m)) begin
                m_cnt++;
                counted = 1'b1;
            end else if (m_armed && n) begin
                if (m_cnt > 0) m_cnt--;
                counted = 1'b1;
            end
            if (m_cnt == LIMIT) m_latch = 1'b1;
            if (s) m_armed = 1'b1;
            else if (counted) m_armed = 1'b0;
        end
        e.cnt = m_cnt;
        e.lat = m_latch;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle_clk();
        step(1'b0, 1'b0, 1'b0, 1'b0, "idle");
    endtask

    // monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.cnt, e.lat, e.tag);
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        compare(0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        idle_clk();

        // R6 strobe before any cycle start is ignored
        step(0, 0, 1, 0, "R6 strobe without open cycle");
        // R2 max on-time ending counts up
        step(1, 0, 0, 0, "R2 start");
        step(0, 0, 1, 0, "R2 maxon increments");
        // R4 normal ending counts down
        step(1, 0, 0, 0, "R4 start");
        step(0, 1, 0, 0, "R4 normal decrements");
        // R5 no underflow
        step(1, 0, 0, 0, "R5 start");
        step(0, 1, 0, 0, "R5 hold at zero");
        // R3 overcurrent counts up, then R6 late normal ignored
        step(1, 0, 0, 0, "R3 start");
        step(0, 0, 0, 1, "R3 ocp increments");
        step(0, 1, 0, 0, "R6 late normal ignored");
        step(0, 0, 1, 0, "R6 late maxon ignored");
        // R7 priority
        step(1, 0, 0, 0, "R7 start");
        step(0, 1, 0, 1, "R7 ocp over normal");
        step(1, 0, 0, 0, "R7 start");
        step(0, 1, 1, 0, "R7 maxon over normal");
        step(1, 0, 0, 0, "R7 start");
        step(0, 1, 1, 1, "R7 all three count once");
        // R8 dimming-cut cycle changes nothing; strobe with start counts old cycle
        step(1, 0, 0, 0, "R8 start");
        idle_clk();
        step(1, 0, 0, 0, "R8 restart with no ending");
        step(1, 1, 0, 0, "R8 normal with start counts");
        step(0, 1, 0, 0, "R8 new cycle normal");
        // climb to the limit: R9
        while (m_cnt < LIMIT - 1) begin
            step(1, 0, 0, 0, "R9 start");
            step(0, 0, 1, 0, "R9 climb");
        end
        step(1, 0, 0, 0, "R9 start");
        step(0, 0, 0, 1, "R9 limit reached latches");
        // R10 everything ignored while latched
        step(1, 0, 0, 0, "R10 start ignored");
        step(0, 1, 0, 0, "R10 normal ignored");
        step(1, 1, 1, 1, "R10 all strobes ignored");
        repeat (3) idle_clk();
        // R10 / R1 supply cycle clears latch
        @(negedge clk);
        rst_n = 1'b0;
        m_cnt = 0; m_armed = 1'b0; m_latch = 1'b0;
        cycle_start = 0; end_normal = 0; end_maxon = 0; end_ocp = 0;
        @(negedge clk);
        compare(0, 1'b0, "R10 reset clears latch");
        rst_n = 1'b1;
        step(1, 0, 0, 0, "R1 start after reset");
        step(0, 0, 1, 0, "R1 counting resumes");
        repeat (3) idle_clk();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule